// File: doc/BRIEF.md
# Sequential Unsigned Byte Multiplier and Divider

This unit takes two byte operands, called A and B, plus an operation select, and produces a new A byte, a new B byte and two flags: carry and overflow. A multiply returns the 16-bit unsigned product, with the low half in A and the high half in B. A divide returns the integer quotient in A and the remainder in B. Both operands are always treated as unsigned. A host raises `start` for one clock while the unit is free. The unit then keeps `busy` high for a fixed window of four machine cycles, where one machine cycle is twelve clocks, so the window is 48 clocks. At the end of the window `done` pulses for one clock.

Each operation is computed one bit per step, with eight steps spaced evenly across the window. The multiply uses shift-and-add and the divide uses restoring shift-and-subtract, which yields quotient bits most significant first. The result and flag outputs change only when an operation completes. They stay unchanged from then on, so the caller may read them at any later time.

The controller has three states:
- ST_IDLE: waiting for work.
- ST_RUN: stepping the datapath.
- ST_DONE: results are valid for this one clock.

The transitions are:
- ST_IDLE to ST_RUN when `start` is seen.
- ST_RUN to ST_DONE on the last clock of the window.
- ST_DONE to ST_RUN when `start` is seen again.
- ST_DONE to ST_IDLE otherwise.

Top module: `muldiv_seq`

## Requirements
- R1: After reset, `busy`, `done`, `a_out`, `b_out`, `cy_out` and `ov_out` are all zero.
- R2: With `op_div` = 0 (multiply), `a_out` is bits 7:0 and `b_out` is bits 15:8 of the unsigned product `a_in` × `b_in`.
- R3: With `op_div` = 1 (divide) and a nonzero `b_in`, `a_out` is the unsigned quotient `a_in` / `b_in` and `b_out` is the remainder `a_in` mod `b_in`.
- R4: A multiply clears `cy_out` and sets `ov_out` exactly when the product exceeds 255.
- R5: A divide clears `cy_out`. It clears `ov_out` when the divisor is nonzero and sets `ov_out` when the divisor is zero.
- R6: An accepted `start` makes `busy` high for exactly 48 clocks (4 machine cycles of 12 clocks each). `done` then rises for exactly one clock, during which `busy` is low.
- R7: A `start` raised while `busy` is high is ignored. The running operation keeps its operands and its completion time.
- R8: The outputs `a_out`, `b_out`, `cy_out` and `ov_out` keep their values between completions, whatever the inputs do. After a divide by zero, `a_out` and `b_out` are unspecified but held stable.
- R9: A `start` raised in the clock where `done` is high is accepted, and the next operation begins immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one oscillator period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation; sampled when not busy |
| op_div | input | 1 | Operation select: 0 = multiply, 1 = divide |
| a_in | input | 8 | Operand A (multiplicand or dividend) |
| b_in | input | 8 | Operand B (multiplier or divisor) |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-clock pulse when results become valid |
| a_out | output | 8 | Result A: product low byte or quotient |
| b_out | output | 8 | Result B: product high byte or remainder |
| cy_out | output | 1 | Carry flag result, cleared by both operations |
| ov_out | output | 1 | Overflow flag: product above 255, or divisor zero |

## Verification
A step counter or phase counter that slips shows up at the ports in one of two ways. Either `done` arrives on the wrong clock, or an operand bit is processed twice or skipped, which corrupts the result. Both are visible on the very next completion, at most 49 clocks after `start`.

If the controller accepts a second `start` while running, the result or the timing of the first operation is damaged. That is caught at its completion. Flags or outputs updated outside the completion clock appear as changes during the hold checks, which run right after a completion.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } md_state_t;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_t;

endpackage

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer #(
    parameter int CLKS_PER_MC = 12,
    parameter int NUM_MC      = 4,
    parameter int NUM_STEPS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic step,
    output logic last
);
    localparam int TOTAL     = CLKS_PER_MC * NUM_MC;
    localparam int STEP_CLKS = (TOTAL / NUM_STEPS) < 1 ? 1 : (TOTAL / NUM_STEPS);
    localparam int CW        = (TOTAL > 1) ? $clog2(TOTAL) : 1;
    localparam int PW        = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam int SW        = $clog2(NUM_STEPS + 1);

    logic [CW-1:0] cnt;
    logic [PW-1:0] phase;
    logic [SW-1:0] steps_taken;

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt         <= '0;
            phase       <= '0;
            steps_taken <= '0;
        end else if (run) begin
            cnt   <= cnt + 1'b1;
            phase <= (phase == PW'(STEP_CLKS - 1)) ? '0 : phase + 1'b1;
            if (step) begin
                steps_taken <= steps_taken + 1'b1;
            end
        end
    end

    always_comb begin
        step = run && (phase == '0) && (steps_taken < SW'(NUM_STEPS));
        last = run && (cnt == CW'(TOTAL - 1));
    end

    // R7: a start during the run must not disturb the window count
    assert_count_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last && !load) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi
);
    logic [W-1:0] hi_q, lo_q, mcand_q;
    logic [W:0]   sum;

    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            mcand_q <= '0;
        end else if (load) begin
            hi_q    <= '0;
            lo_q    <= a;
            mcand_q <= b;
        end else if (step) begin
            hi_q <= sum[W:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
        end
    end

    assign prod_lo = lo_q;
    assign prod_hi = hi_q;

endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         dvsr_zero
);
    logic [W-1:0] rem_q, quo_q, dvsr_q;
    logic [W:0]   shifted, diff;
    logic         fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        fits    = (shifted >= {1'b0, dvsr_q});
        diff    = shifted - {1'b0, dvsr_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= a;
            dvsr_q <= b;
        end else if (step) begin
            rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
        end
    end

    assign quot      = quo_q;
    assign rem       = rem_q;
    assign dvsr_zero = (dvsr_q == '0);

    // R3: the partial remainder never reaches the divisor
    assert_partial_rem_below_dvsr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dvsr_q != '0) |-> (rem_q < dvsr_q));

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int W           = 8,
    parameter int CLKS_PER_MC = 12,
    parameter int NUM_MC      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_div,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         cy_out,
    output logic         ov_out
);
    md_state_t    state, state_nx;
    md_op_t       op_q;
    logic         accept, step, last;
    logic [W-1:0] m_lo, m_hi, d_quo, d_rem;
    logic         d_zero;
    logic [W-1:0] res_a, res_b;
    logic         res_ov;

    assign accept = start && (state != ST_RUN);

    mcyc_sequencer #(
        .CLKS_PER_MC(CLKS_PER_MC),
        .NUM_MC     (NUM_MC),
        .NUM_STEPS  (W)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .run  (state == ST_RUN),
        .step (step),
        .last (last)
    );

    mul_shift_add #(.W(W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (step && (op_q == OP_MUL)),
        .a      (a_in),
        .b      (b_in),
        .prod_lo(m_lo),
        .prod_hi(m_hi)
    );

    div_restoring #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step && (op_q == OP_DIV)),
        .a        (a_in),
        .b        (b_in),
        .quot     (d_quo),
        .rem      (d_rem),
        .dvsr_zero(d_zero)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (last)  state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_RUN : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_MUL;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q <= md_op_t'(op_div);
            end
        end
    end

    always_comb begin
        busy = (state == ST_RUN);
        done = (state == ST_DONE);
    end

    always_comb begin
        if (op_q == OP_DIV) begin
            res_a  = d_quo;
            res_b  = d_rem;
            res_ov = d_zero;
        end else begin
            res_a  = m_lo;
            res_b  = m_hi;
            res_ov = (m_hi != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_out  <= '0;
            b_out  <= '0;
            cy_out <= 1'b0;
            ov_out <= 1'b0;
        end else if (state == ST_RUN && last) begin
            a_out  <= res_a;
            b_out  <= res_b;
            cy_out <= 1'b0;
            ov_out <= res_ov;
        end
    end

    // R6: done lasts one clock and never overlaps busy
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && $past(busy)));
    // R8: results change only on the completion edge
    assert_results_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({a_out, b_out, cy_out, ov_out}));
    // R4: multiply overflow mirrors a nonzero high byte
    assert_mul_ov_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_MUL) |-> (ov_out == (b_out != '0)));

endmodule

// File: tb/sim_muldiv_seq.sv
module sim_muldiv_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CLKS  = 4 * 12;
    localparam int NVEC       = 13;

    // {op, a, b, expected a, expected b, expected ov}
    localparam logic [33:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {1'b0, 8'hFF, 8'hFF, 8'h01, 8'hFE, 1'b1},
        {1'b0, 8'h10, 8'h10, 8'h00, 8'h01, 1'b1},
        {1'b0, 8'h0F, 8'h11, 8'hFF, 8'h00, 1'b0},
        {1'b0, 8'h25, 8'h04, 8'h94, 8'h00, 1'b0},
        {1'b0, 8'h80, 8'h02, 8'h00, 8'h01, 1'b1},
        {1'b1, 8'hFF, 8'h01, 8'hFF, 8'h00, 1'b0},
        {1'b1, 8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0},
        {1'b1, 8'h07, 8'h09, 8'h00, 8'h07, 1'b0},
        {1'b1, 8'h64, 8'h07, 8'h0E, 8'h02, 1'b0},
        {1'b1, 8'h00, 8'h05, 8'h00, 8'h00, 1'b0},
        {1'b1, 8'h80, 8'h03, 8'h2A, 8'h02, 1'b0},
        {1'b1, 8'h37, 8'h00, 8'h00, 8'h00, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op_div = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic       busy, done, cy_out, ov_out;
    logic [7:0] a_out, b_out;

    int total = 0;
    int bad = 0;
    int busy_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    muldiv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
        .a_out(a_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic op, input logic [7:0] a, input logic [7:0] b,
                          input int poke, input bit b2b);
        if (!b2b) @(negedge clk);
        start = 1'b1; op_div = op; a_in = a; b_in = b;
        @(negedge clk);
        start = 1'b0;
        busy_n = 0;
        while (!done && busy_n < 500) begin
            if (busy) busy_n++;
            if (poke > 0 && busy_n == poke) begin
                start = 1'b1; op_div = ~op; a_in = 8'hC8; b_in = 8'h07;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R6", "busy clocks", busy_n, BUSY_CLKS);
        check("R6", "busy at done", int'(busy), 0);
    endtask

    task automatic check_result(input logic op, input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = 16'(a) * 16'(b);
        if (!op) begin
            check("R2", "mul low", int'(a_out), int'(p[7:0]));
            check("R2", "mul high", int'(b_out), int'(p[15:8]));
            check("R4", "mul cy", int'(cy_out), 0);
            check("R4", "mul ov", int'(ov_out), int'(p > 16'd255));
        end else begin
            if (b != 0) begin
                check("R3", "quotient", int'(a_out), int'(a / b));
                check("R3", "remainder", int'(b_out), int'(a % b));
            end
            check("R5", "div cy", int'(cy_out), 0);
            check("R5", "div ov", int'(ov_out), int'(b == 0));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] ha, hb;
        logic       hc, hv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "outputs", int'({a_out, b_out, cy_out, ov_out}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [33:0] v;
            v = VEC[i];
            run_op(v[33], v[32:25], v[24:17], 0, 1'b0);
            if (!(v[33] && v[24:17] == 8'h00)) begin
                check(v[33] ? "R3" : "R2", "vec a", int'(a_out), int'(v[16:9]));
                check(v[33] ? "R3" : "R2", "vec b", int'(b_out), int'(v[8:1]));
            end
            check(v[33] ? "R5" : "R4", "vec ov", int'(ov_out), int'(v[0]));
            check(v[33] ? "R5" : "R4", "vec cy", int'(cy_out), 0);
        end

        for (int i = 0; i < 64; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 53 + 7);
            b = 8'(i * 29 + 3);
            run_op(1'b0, a, b, 0, 1'b0);
            check_result(1'b0, a, b);
            run_op(1'b1, a, b, 0, 1'b0);
            check_result(1'b1, a, b);
        end

        // R7: start raised mid-run with other operands is ignored
        run_op(1'b0, 8'h03, 8'h05, 10, 1'b0);
        check("R7", "a after ignored start", int'(a_out), 8'h0F);
        check("R7", "b after ignored start", int'(b_out), 8'h00);

        // R8: hold after a divide by zero while inputs wander
        run_op(1'b1, 8'h5A, 8'h00, 0, 1'b0);
        check("R5", "div0 ov", int'(ov_out), 1);
        ha = a_out; hb = b_out; hc = cy_out; hv = ov_out;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            a_in = 8'(k * 17); b_in = 8'(k * 5 + 1); op_div = k[0];
        end
        check("R8", "held a", int'(a_out), int'(ha));
        check("R8", "held b", int'(b_out), int'(hb));
        check("R8", "held flags", int'({hc, hv}), int'({cy_out, ov_out}));
        check("R8", "idle busy", int'(busy), 0);

        // R9: start in the done clock is accepted
        run_op(1'b0, 8'h0C, 8'h0D, 0, 1'b0);
        check_result(1'b0, 8'h0C, 8'h0D);
        run_op(1'b1, 8'hC8, 8'h0B, 0, 1'b1);
        check_result(1'b1, 8'hC8, 8'h0B);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule